// File: doc/BRIEF.md
# DMA Burst Boundary Splitter

This block plans one dual-address DMA transfer as a stream of burst commands. It is given a source start address, a destination start address, a byte count, a transfer-size code, a FIFO-use enable, a size-mode bit and the direction of each address. From these it issues one command at a time. Each command carries a byte length, a source address and a destination address. No command crosses a 128-byte (32-word) boundary on either side.

A command is offered with a valid/ready handshake. Once the command is taken, the block waits for a completion acknowledge before it advances both addresses and the remaining count. The data path, the FIFO and the bus protocol sit outside this block. A start with an illegal configuration issues no command and raises a one-cycle error pulse. A transfer ends with a one-cycle done pulse.

Top module: `dma_burst_splitter`

## Requirements
- R1: `size_code_i` selects the set size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 16 bytes, 4 = 32 bytes, 5 = 64 bytes and 6 = 128 bytes. The effective maximum length is the set size only when the code is 3 or 4 and `fifo_en_i` is 1. Otherwise it is the smaller of the set size and 4 bytes, which makes every transaction a single transfer.
- R2: On each side, no command crosses a 128-byte boundary. For an incrementing side the room is 128 − addr[6:0]. For a decrementing side it is addr[6:0] + 1.
- R3: With `size_mode_i` = 0, a command on each side also stops at the next address that is a multiple of the effective size. That limit is E − (addr mod E) when incrementing and (addr mod E) + 1 when decrementing.
- R4: With `size_mode_i` = 1, splitting ignores the offset against the set size. Only the 128-byte rooms, the effective size and the remaining count limit the length. For example, source offset 0x54 and destination offset 0x1C with 32-byte bursts give lengths 32, 12, 20 for 64 bytes.
- R5: The command length is the minimum of the remaining count, the effective size and the rooms of R2 and R3. It is never zero.
- R6: On an acknowledge, each address moves by the command length: it adds when `*_dec_i` = 0 and subtracts when it is 1. The remaining count falls by the same amount.
- R7: A decrementing side names the highest byte of its first word, so its address has low bits 0b11. An incrementing side has low bits 0b00. The rooms of R2 and R3 are measured from that address.
- R8: The start is rejected in two cases: the size code is 7, or the code is 3 to 6 and either address breaks the low-bit rule of R7. A rejected start pulses `cfg_err_o` for one cycle one clock after the start, issues no command and leaves `busy_o` low.
- R9: `cmd_valid_o` stays high with a stable payload until `cmd_ready_i`. After acceptance no new command appears until `ack_i`. `ack_i` has no effect unless a command has been accepted.
- R10: `done_o` pulses for one cycle in the clock after the acknowledge that brings the remaining count to zero. A start with a zero count pulses `done_o` one clock after the start and issues no command.
- R11: `start_i` is ignored while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transfer with the current settings |
| src_addr_i | input | ADDR_W | Source start address |
| dst_addr_i | input | ADDR_W | Destination start address |
| byte_cnt_i | input | CNT_W | Total bytes to move |
| size_code_i | input | 3 | Transfer-size code (R1) |
| fifo_en_i | input | 1 | FIFO-use enable, allows bursts |
| size_mode_i | input | 1 | 1: boundary-only splitting, 0: also align each side |
| src_dec_i | input | 1 | Source address decrements |
| dst_dec_i | input | 1 | Destination address decrements |
| cmd_valid_o | output | 1 | Command offered |
| cmd_ready_i | input | 1 | Command taken |
| cmd_len_o | output | LEN_W | Command length in bytes |
| cmd_src_o | output | ADDR_W | Command source address |
| cmd_dst_o | output | ADDR_W | Command destination address |
| ack_i | input | 1 | Accepted command completed |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer finished, one-cycle pulse |
| cfg_err_o | output | 1 | Start rejected, one-cycle pulse |

## Verification
The hardest situation to reach is a command whose length is set by the far side's room rather than the near side's. This happens when source and destination sit at different offsets inside their 128-byte windows, and in opposite directions. Random starts draw independent offsets and directions, and most of them keep the low-bit rule legal so that transfers actually run. Directed starts cover the 0x54/0x1C case in both size modes, a decrementing source, zero count, rejected configurations and a start pulse raised during a transfer.

// File: rtl/dma_bsplit_pkg.sv
`timescale 1ns/1ps
package dma_bsplit_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} st_e;

  localparam logic [2:0] SZ_W4  = 3'd3;
  localparam logic [2:0] SZ_W8  = 3'd4;
  localparam logic [2:0] SZ_BAD = 3'd7;
endpackage

// File: rtl/dma_bsplit_cfg.sv
`timescale 1ns/1ps
module dma_bsplit_cfg
  import dma_bsplit_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic [2:0]       size_code_i,
  input  logic             fifo_en_i,
  input  logic [1:0]       src_lo_i,
  input  logic [1:0]       dst_lo_i,
  input  logic             src_dec_i,
  input  logic             dst_dec_i,
  output logic [LEN_W-1:0] eff_size_o,
  output logic             cfg_err_o
);
  logic [LEN_W-1:0] unit;
  logic             burst_ok;
  logic             word_class;

  always_comb begin
    unit = LEN_W'(4);
    case (size_code_i)
      3'd0: unit = LEN_W'(1);
      3'd1: unit = LEN_W'(2);
      3'd2: unit = LEN_W'(4);
      3'd3: unit = LEN_W'(16);
      3'd4: unit = LEN_W'(32);
      3'd5: unit = LEN_W'(64);
      3'd6: unit = LEN_W'(128);
      default: unit = LEN_W'(4);
    endcase
  end

  assign burst_ok   = fifo_en_i && (size_code_i == SZ_W4 || size_code_i == SZ_W8);
  assign word_class = (size_code_i >= SZ_W4) && (size_code_i != SZ_BAD);

  always_comb begin
    if (burst_ok || unit < LEN_W'(4)) eff_size_o = unit;
    else                              eff_size_o = LEN_W'(4);
  end

  assign cfg_err_o = (size_code_i == SZ_BAD) ||
                     (word_class && ((src_lo_i != {2{src_dec_i}}) ||
                                     (dst_lo_i != {2{dst_dec_i}})));

  always_comb begin
    a_eff_pow2_R1: assert ((eff_size_o & (eff_size_o - LEN_W'(1))) == '0 && eff_size_o != '0);
  end
endmodule

// File: rtl/dma_bsplit_room.sv
`timescale 1ns/1ps
module dma_bsplit_room #(
  parameter int BOUND_BYTES = 128,
  parameter int LEN_W       = 8,
  localparam int OFF_W      = $clog2(BOUND_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OFF_W-1:0] off_i,
  input  logic             dec_i,
  input  logic             align_en_i,
  input  logic [LEN_W-1:0] eff_i,
  output logic [LEN_W-1:0] room_o
);
  logic [LEN_W-1:0] off_x, part, bnd, algn;

  always_comb begin
    off_x = LEN_W'(off_i);
    part  = off_x & (eff_i - LEN_W'(1));
    bnd   = dec_i ? off_x + LEN_W'(1) : LEN_W'(BOUND_BYTES) - off_x;
    algn  = dec_i ? part + LEN_W'(1)  : eff_i - part;
    room_o = (align_en_i && algn < bnd) ? algn : bnd;
  end

  a_room_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    room_o != '0 && room_o <= LEN_W'(BOUND_BYTES));
endmodule

// File: rtl/dma_bsplit_ctrl.sv
`timescale 1ns/1ps
module dma_bsplit_ctrl
  import dma_bsplit_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int BOUND_BYTES = 128,
  parameter int LEN_W       = 8,
  localparam int OFF_W      = $clog2(BOUND_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  input  logic              size_mode_i,
  input  logic              src_dec_i,
  input  logic              dst_dec_i,
  input  logic [LEN_W-1:0]  eff_size_i,
  input  logic              cfg_err_i,
  input  logic [LEN_W-1:0]  room_src_i,
  input  logic [LEN_W-1:0]  room_dst_i,
  output logic [OFF_W-1:0]  src_off_o,
  output logic [OFF_W-1:0]  dst_off_o,
  output logic              src_dec_o,
  output logic              dst_dec_o,
  output logic              align_en_o,
  output logic [LEN_W-1:0]  eff_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [LEN_W-1:0]  cmd_len_o,
  output logic [ADDR_W-1:0] cmd_src_o,
  output logic [ADDR_W-1:0] cmd_dst_o,
  input  logic              ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              cfg_err_o
);
  st_e              state_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  rem_q;
  logic [LEN_W-1:0]  eff_q, len_q, len_d, rem_fit, room_min;
  logic              sdec_q, ddec_q, mode_q, done_q, err_q;

  always_comb begin
    rem_fit  = (rem_q >= CNT_W'(eff_q)) ? eff_q : LEN_W'(rem_q);
    room_min = (room_src_i < room_dst_i) ? room_src_i : room_dst_i;
    len_d    = (rem_fit < room_min) ? rem_fit : room_min;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      rem_q   <= '0;
      eff_q   <= LEN_W'(1);
      len_q   <= '0;
      sdec_q  <= 1'b0;
      ddec_q  <= 1'b0;
      mode_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          if (cfg_err_i)             err_q  <= 1'b1;
          else if (byte_cnt_i == '0) done_q <= 1'b1;
          else begin
            src_q   <= src_addr_i;
            dst_q   <= dst_addr_i;
            rem_q   <= byte_cnt_i;
            eff_q   <= eff_size_i;
            sdec_q  <= src_dec_i;
            ddec_q  <= dst_dec_i;
            mode_q  <= size_mode_i;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (cmd_ready_i) begin
          len_q   <= len_d;
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (ack_i) begin
          src_q <= sdec_q ? src_q - ADDR_W'(len_q) : src_q + ADDR_W'(len_q);
          dst_q <= ddec_q ? dst_q - ADDR_W'(len_q) : dst_q + ADDR_W'(len_q);
          rem_q <= rem_q - CNT_W'(len_q);
          if (rem_q == CNT_W'(len_q)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_ISSUE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign src_off_o   = src_q[OFF_W-1:0];
  assign dst_off_o   = dst_q[OFF_W-1:0];
  assign src_dec_o   = sdec_q;
  assign dst_dec_o   = ddec_q;
  assign align_en_o  = !mode_q;
  assign eff_o       = eff_q;
  assign cmd_valid_o = (state_q == ST_ISSUE);
  assign cmd_len_o   = len_d;
  assign cmd_src_o   = src_q;
  assign cmd_dst_o   = dst_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign cfg_err_o   = err_q;

  a_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_len_o) &&
                                    $stable(cmd_src_o) && $stable(cmd_dst_o));
  a_one_out_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ready_i |=> !cmd_valid_o);
  a_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> cmd_len_o != '0 && cmd_len_o <= eff_q && CNT_W'(cmd_len_o) <= rem_q);
  a_src_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (sdec_q ? ({1'b0, cmd_len_o} <= ({1'b0, LEN_W'(src_off_o)} + 9'(1)))
                            : ({1'b0, LEN_W'(src_off_o)} + {1'b0, cmd_len_o} <= 9'(BOUND_BYTES))));
  a_dst_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (ddec_q ? ({1'b0, cmd_len_o} <= ({1'b0, LEN_W'(dst_off_o)} + 9'(1)))
                            : ({1'b0, LEN_W'(dst_off_o)} + {1'b0, cmd_len_o} <= 9'(BOUND_BYTES))));
  a_done_ack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && ($past(ack_i) || $past(start_i)));
  a_err_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !busy_o && !cmd_valid_o && !done_o);
endmodule

// File: rtl/dma_burst_splitter.sv
`timescale 1ns/1ps
module dma_burst_splitter #(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int BOUND_BYTES = 128,
  localparam int LEN_W      = $clog2(BOUND_BYTES) + 1,
  localparam int OFF_W      = $clog2(BOUND_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  input  logic [2:0]        size_code_i,
  input  logic              fifo_en_i,
  input  logic              size_mode_i,
  input  logic              src_dec_i,
  input  logic              dst_dec_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [LEN_W-1:0]  cmd_len_o,
  output logic [ADDR_W-1:0] cmd_src_o,
  output logic [ADDR_W-1:0] cmd_dst_o,
  input  logic              ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              cfg_err_o
);
  logic [LEN_W-1:0] eff_size, eff_q;
  logic             cfg_err, align_en;
  logic [OFF_W-1:0] off   [2];
  logic             dec   [2];
  logic [LEN_W-1:0] room  [2];

  dma_bsplit_cfg #(.LEN_W(LEN_W)) u_cfg (
    .size_code_i (size_code_i),
    .fifo_en_i   (fifo_en_i),
    .src_lo_i    (src_addr_i[1:0]),
    .dst_lo_i    (dst_addr_i[1:0]),
    .src_dec_i   (src_dec_i),
    .dst_dec_i   (dst_dec_i),
    .eff_size_o  (eff_size),
    .cfg_err_o   (cfg_err)
  );

  for (genvar s = 0; s < 2; s++) begin : g_side
    dma_bsplit_room #(.BOUND_BYTES(BOUND_BYTES), .LEN_W(LEN_W)) u_room (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .off_i      (off[s]),
      .dec_i      (dec[s]),
      .align_en_i (align_en),
      .eff_i      (eff_q),
      .room_o     (room[s])
    );
  end

  dma_bsplit_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BOUND_BYTES(BOUND_BYTES), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .src_addr_i  (src_addr_i),
    .dst_addr_i  (dst_addr_i),
    .byte_cnt_i  (byte_cnt_i),
    .size_mode_i (size_mode_i),
    .src_dec_i   (src_dec_i),
    .dst_dec_i   (dst_dec_i),
    .eff_size_i  (eff_size),
    .cfg_err_i   (cfg_err),
    .room_src_i  (room[0]),
    .room_dst_i  (room[1]),
    .src_off_o   (off[0]),
    .dst_off_o   (off[1]),
    .src_dec_o   (dec[0]),
    .dst_dec_o   (dec[1]),
    .align_en_o  (align_en),
    .eff_o       (eff_q),
    .cmd_valid_o (cmd_valid_o),
    .cmd_ready_i (cmd_ready_i),
    .cmd_len_o   (cmd_len_o),
    .cmd_src_o   (cmd_src_o),
    .cmd_dst_o   (cmd_dst_o),
    .ack_i       (ack_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .cfg_err_o   (cfg_err_o)
  );
endmodule

// File: tb/dma_burst_splitter_test.sv
`timescale 1ns/1ps
module dma_burst_splitter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] src_a = '0, dst_a = '0;
  logic [15:0] cnt = '0;
  logic [2:0]  code = '0;
  logic        fifo = 1'b0, mode = 1'b0, sdec = 1'b0, ddec = 1'b0;
  logic        ready = 1'b0, ack = 1'b0;
  logic        valid, busy, done, err;
  logic [7:0]  len;
  logic [31:0] csrc, cdst;

  int tests = 0, fails = 0, cycles = 0;
  bit poke_start = 1'b0;

  always #2.5 clk = ~clk;

  dma_burst_splitter uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .src_addr_i(src_a), .dst_addr_i(dst_a), .byte_cnt_i(cnt),
    .size_code_i(code), .fifo_en_i(fifo), .size_mode_i(mode),
    .src_dec_i(sdec), .dst_dec_i(ddec),
    .cmd_valid_o(valid), .cmd_ready_i(ready), .cmd_len_o(len),
    .cmd_src_o(csrc), .cmd_dst_o(cdst), .ack_i(ack),
    .busy_o(busy), .done_o(done), .cfg_err_o(err)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, act=%0d exp<=150000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic int eff_of(int c, bit f);
    int u = (c < 3) ? (1 << c) : (16 << (c - 3));
    if (f && (c == 3 || c == 4)) return u;
    return (u < 4) ? u : 4;
  endfunction

  function automatic int room_of(int a, bit d, bit m, int e);
    int off = a & 127;
    int b = d ? off + 1 : 128 - off;
    int al = d ? (off % e) + 1 : e - (off % e);
    if (!m && al < b) return al;
    return b;
  endfunction

  function automatic bit bad_cfg(int c, int sa, int da, bit sd, bit dd);
    if (c == 7) return 1'b1;
    if (c >= 3 && (((sa & 3) != (sd ? 3 : 0)) || ((da & 3) != (dd ? 3 : 0)))) return 1'b1;
    return 1'b0;
  endfunction

  task automatic run_xfer(int sa, int da, int n, int c, bit f, bit m, bit sd, bit dd);
    int e = eff_of(c, f);
    int rs = sa, rd = da, rem = n;
    bit bad = bad_cfg(c, sa, da, sd, dd);
    bit first = 1'b1;
    @(negedge clk);
    src_a = sa; dst_a = da; cnt = 16'(n); code = 3'(c);
    fifo = f; mode = m; sdec = sd; ddec = dd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (bad) begin
      chk("R8 cfg_err pulse", int'(err), 1);
      chk("R8 no command", int'(valid), 0);
      @(negedge clk);
      chk("R8 pulse ends, idle", int'({err, busy, valid}), 0);
      return;
    end
    if (n == 0) begin
      chk("R10 zero count done", int'(done), 1);
      chk("R10 zero count no cmd", int'(valid), 0);
      return;
    end
    while (rem > 0) begin
      int exp_len = rem;
      int w, rs_room, rd_room;
      if (e < exp_len) exp_len = e;
      rs_room = room_of(rs, sd, m, e);
      rd_room = room_of(rd, dd, m, e);
      if (rs_room < exp_len) exp_len = rs_room;
      if (rd_room < exp_len) exp_len = rd_room;
      chk("R9 command offered", int'(valid), 1);
      chk(m ? "R4 len (boundary only)" : "R3 len (aligned)", int'(len), exp_len);
      chk("R6 src addr", int'(csrc), rs);
      chk("R6 dst addr", int'(cdst), rd);
      w = $urandom_range(0, 2);
      if (first && poke_start) w = 2;
      for (int i = 0; i < w; i++) begin
        if (first && poke_start && i == 0) begin
          src_a = 32'h5; code = 3'd7; cnt = 16'd0; start = 1'b1;
        end
        @(negedge clk);
        start = 1'b0;
        chk("R9/R11 held payload", int'({valid, len}), int'({1'b1, 8'(exp_len)}));
        chk("R11 no error on busy start", int'(err), 0);
      end
      ready = 1'b1;
      @(negedge clk);
      ready = 1'b0;
      chk("R9 one outstanding", int'(valid), 0);
      w = $urandom_range(0, 2);
      for (int i = 0; i < w; i++) begin
        @(negedge clk);
        chk("R9 wait for ack", int'({valid, done}), 0);
      end
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      rs = sd ? rs - exp_len : rs + exp_len;
      rd = dd ? rd - exp_len : rd + exp_len;
      rem -= exp_len;
      first = 1'b0;
      chk("R10 done timing", int'(done), (rem == 0) ? 1 : 0);
    end
    @(negedge clk);
    chk("R10 single-cycle done", int'({done, busy}), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("reset outputs", int'({valid, busy, done, err}), 0);
    rst_n = 1'b1;
    // R4: offsets 0x54 / 0x1C, 32-byte bursts, boundary-only
    run_xfer(32'h0001_0054, 32'h0002_001C, 64, 4, 1, 1, 0, 0);
    // R3: same start, aligned splitting
    run_xfer(32'h0001_0054, 32'h0002_001C, 64, 4, 1, 0, 0, 0);
    // R7: decrementing source at 0x...03
    run_xfer(32'h0001_0003, 32'h0000_0200, 40, 4, 1, 1, 1, 0);
    run_xfer(32'h0001_0073, 32'h0000_02FC, 100, 3, 1, 0, 1, 0);
    // R1: 8-word code without FIFO, 16-word code with FIFO => single words
    run_xfer(32'h0000_0010, 32'h0000_0020, 20, 4, 0, 1, 0, 0);
    run_xfer(32'h0000_0040, 32'h0000_0080, 12, 5, 1, 1, 0, 0);
    run_xfer(32'h0000_0041, 32'h0000_0083, 7, 1, 0, 0, 0, 1);
    // R10 zero count, R8 bad configs
    run_xfer(32'h0000_0000, 32'h0000_0000, 0, 2, 0, 0, 0, 0);
    run_xfer(32'h0000_0000, 32'h0000_0000, 8, 7, 0, 0, 0, 0);
    run_xfer(32'h0000_0001, 32'h0000_0000, 8, 4, 1, 0, 0, 0);
    run_xfer(32'h0000_0000, 32'h0000_0000, 8, 3, 1, 0, 0, 1);
    // R11: start raised mid-transfer is ignored
    poke_start = 1'b1;
    run_xfer(32'h0000_0070, 32'h0000_0004, 48, 4, 1, 1, 0, 0);
    poke_start = 1'b0;
    for (int k = 0; k < 60; k++) begin
      int c = $urandom_range(0, 7);
      bit sd = 1'($urandom_range(0, 1));
      bit dd = 1'($urandom_range(0, 1));
      int sa = $urandom & 32'hFFFF_FFFC;
      int da = $urandom & 32'hFFFF_FFFC;
      if (sd) sa |= 3;
      if (dd) da |= 3;
      if ($urandom_range(0, 9) == 0) sa ^= 1;
      if (c == 7 && $urandom_range(0, 1) == 1) c = 4;
      run_xfer(sa, da, $urandom_range(0, 200), c, 1'($urandom_range(0, 3) != 0),
               1'($urandom_range(0, 1)), sd, dd);
    end
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule